// File: doc/BRIEF.md
# SMBus Host I2C Block-Read Sequencer

This core is the host side of an SMBus controller, reduced to one job: an I2C-style block read whose length is never programmed. Software loads a slave address and a command byte, then sets a start bit. The core addresses the slave for writing and sends the command byte. It then issues a repeated start with the read direction and receives the first byte into a data register.

From there on, software sets the pace. Each time it clears the byte-done status flag, the core fetches one more byte. Before it clears byte-done for the last time, software sets a last-byte control bit. The core then receives one final byte, answers it with a NACK, ends the transfer with a stop and raises the completion status. A kill bit ends a transfer at any point with a stop.

The I2C side is an abstract byte-level master port made of two streams. The command stream (`bus_cmd_*`) carries START, SEND, RECV_ACK, RECV_NACK and STOP operations. The response stream (`bus_rsp_*`) returns one answer per operation. Back-pressure rules:
- On the command stream, once valid is raised, the operation and the byte stay stable until ready is seen on a clock edge.
- The response stream is accepted only while `bus_rsp_ready` is high.
- At most one operation is outstanding: no new command is offered until the response to the previous one has been taken.

Top module: `smb_blkrd_host`

## Requirements
- R1: A start writes slave byte {a[6:0], 0}, where a = the slave-address register bits [7:1]. It then sends the command register, then writes START {a[6:0], 1}. Bit 0 of the slave-address register has no effect on any of these bytes. Register addresses: control 0, status 1, command 2, slave address 3, data 4 (read only).
- R2: If the slave NACKs the first START, the SEND or the second START, the core issues one STOP and nothing else. It then sets device-error (status bit 2) and clears busy (status bit 0).
- R3: After the repeated start, the first byte is received with RECV_ACK into the data register. The status then reads busy=1 and byte-done=1 (bit 3), i.e. 0x09.
- R4: Writing 1 to a status bit clears it, except busy, which a status write leaves unchanged.
- R5: A status write that does not clear a set byte-done bit (bit 3) leaves the data register unchanged, issues no bus operation and leaves byte-done set.
- R6: Clearing byte-done while the last-byte control bit (control bit 3) is set makes the core do three things: one RECV_NACK into the data register, then exactly one STOP, then status = done (bit 1) with busy clear.
- R7: Clearing byte-done while the last-byte bit is clear makes the core receive the next byte with RECV_ACK into the data register and set byte-done again.
- R8: Writing the kill bit (control bit 2) while busy makes the core issue one STOP after any operation already in flight. It then clears busy and byte-done and does not set done.
- R9: `irq` is high exactly when interrupt-enable (control bit 0) is set and any of status bits 1..3 is set.
- R10: A command held without ready stays stable in op and byte. No command is offered while a response is awaited.
- R11: Writing the start bit (control bit 1) while busy is ignored and issues no bus operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational, no side effects) |
| irq | output | 1 | Interrupt request |
| bus_cmd_valid | output | 1 | Bus operation offered |
| bus_cmd_ready | input | 1 | Bus operation accepted |
| bus_cmd_op | output | 3 | Operation: 0 START, 1 SEND, 2 RECV_ACK, 3 RECV_NACK, 4 STOP |
| bus_cmd_byte | output | 8 | Address byte for START, data byte for SEND |
| bus_rsp_valid | input | 1 | Response available |
| bus_rsp_ready | output | 1 | Core awaits a response |
| bus_rsp_byte | input | 8 | Received byte for RECV operations |
| bus_rsp_nack | input | 1 | Slave did not acknowledge a START or SEND |

## Verification
Properties check the following on every cycle:
- the command stream holds stable under back-pressure and never overlaps an awaited response;
- the direction bit of each START follows its position in the transfer;
- the only operation allowed after a RECV_NACK is a STOP;
- byte-done is never set without busy;
- a status write that leaves byte-done alone does not advance the transfer;
- `irq` stays low while interrupts are disabled.

Only the bench scenarios can show the following:
- the full operation order and the received byte values against an incrementing slave pattern;
- the exact status words after NACKed address and command phases;
- the kill path and the ignored start;
- that exactly one STOP follows each transfer.

// File: rtl/smb_blkrd_pkg.sv
package smb_blkrd_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_CMD   = 3'd2;
  localparam logic [REG_AW-1:0] RA_SLAVE = 3'd3;
  localparam logic [REG_AW-1:0] RA_DATA  = 3'd4;

  localparam int CB_IRQEN = 0;
  localparam int CB_START = 1;
  localparam int CB_KILL  = 2;
  localparam int CB_LAST  = 3;

  localparam int SB_BUSY   = 0;
  localparam int SB_DONE   = 1;
  localparam int SB_DEVERR = 2;
  localparam int SB_BYTE   = 3;
  localparam int STAT_W    = 4;

  typedef enum logic [2:0] {
    OP_START     = 3'd0,
    OP_SEND      = 3'd1,
    OP_RECV_ACK  = 3'd2,
    OP_RECV_NACK = 3'd3,
    OP_STOP      = 3'd4
  } bus_op_e;

  typedef enum logic [2:0] {
    STEP_AW, STEP_CMD, STEP_AR, STEP_RX, STEP_RXL,
    STEP_STOP_OK, STEP_STOP_ERR, STEP_STOP_KILL
  } step_e;

  typedef struct packed {
    logic data;       // load received byte
    logic byte_done;  // set byte-done
    logic fin;        // transfer complete
    logic err;        // device error
    logic abort;      // killed
  } ev_t;
endpackage

// File: rtl/smb_blkrd_regs.sv
module smb_blkrd_regs
  import smb_blkrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  ev_t               ev,
  input  logic [DW-1:0]     ev_byte,
  output logic              go,
  output logic              advance,
  output logic              kill,
  output logic              last_byte,
  output logic              irq_en,
  output logic [DW-1:0]     cmd_byte,
  output logic [DW-1:0]     slave_byte,
  output logic [DW-1:0]     stat,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [DW-1:0]     data_q;
  logic              wr_ctrl, wr_stat;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);

  assign go      = wr_ctrl && reg_wdata[CB_START] && !stat_q[SB_BUSY];
  assign kill    = wr_ctrl && reg_wdata[CB_KILL] && stat_q[SB_BUSY];
  assign advance = wr_stat && reg_wdata[SB_BYTE] && stat_q[SB_BYTE];

  always_comb begin
    stat_d = stat_q;
    if (wr_stat)
      stat_d[STAT_W-1:1] = stat_q[STAT_W-1:1] & ~reg_wdata[STAT_W-1:1];
    if (go)           stat_d[SB_BUSY] = 1'b1;
    if (ev.byte_done) stat_d[SB_BYTE] = 1'b1;
    if (ev.fin) begin
      stat_d[SB_DONE] = 1'b1;
      stat_d[SB_BUSY] = 1'b0;
    end
    if (ev.err) begin
      stat_d[SB_DEVERR] = 1'b1;
      stat_d[SB_BUSY]   = 1'b0;
    end
    if (ev.abort) begin
      stat_d[SB_BUSY] = 1'b0;
      stat_d[SB_BYTE] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      data_q     <= '0;
      irq_en     <= 1'b0;
      last_byte  <= 1'b0;
      cmd_byte   <= '0;
      slave_byte <= '0;
    end else begin
      stat_q <= stat_d;
      if (ev.data) data_q <= ev_byte;
      if (wr_ctrl) begin
        irq_en    <= reg_wdata[CB_IRQEN];
        last_byte <= reg_wdata[CB_LAST];
      end
      if (reg_wr && reg_addr == RA_CMD)   cmd_byte   <= reg_wdata;
      if (reg_wr && reg_addr == RA_SLAVE) slave_byte <= reg_wdata;
    end
  end

  assign stat = {{(DW-STAT_W){1'b0}}, stat_q};
  assign irq  = irq_en && (|stat_q[STAT_W-1:1]);

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {{(DW-4){1'b0}}, last_byte, 2'b00, irq_en};
      RA_STAT:  reg_rdata = stat;
      RA_CMD:   reg_rdata = cmd_byte;
      RA_SLAVE: reg_rdata = slave_byte;
      RA_DATA:  reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smb_blkrd_link.sv
module smb_blkrd_link
  import smb_blkrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  bus_op_e       req_op,
  input  logic [DW-1:0] req_byte,
  output logic          done,
  output logic [DW-1:0] done_byte,
  output logic          done_nack,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output bus_op_e       cmd_op,
  output logic [DW-1:0] cmd_byte,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_byte,
  input  logic          rsp_nack
);
  typedef enum logic [1:0] {L_IDLE, L_CMD, L_RSP} lst_e;
  lst_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= L_IDLE;
      cmd_op    <= OP_STOP;
      cmd_byte  <= '0;
      done      <= 1'b0;
      done_byte <= '0;
      done_nack <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        L_IDLE: if (req) begin
          st_q     <= L_CMD;
          cmd_op   <= req_op;
          cmd_byte <= req_byte;
        end
        L_CMD: if (cmd_ready) st_q <= L_RSP;
        L_RSP: if (rsp_valid) begin
          st_q      <= L_IDLE;
          done      <= 1'b1;
          done_byte <= rsp_byte;
          done_nack <= rsp_nack;
        end
        default: st_q <= L_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st_q == L_CMD);
  assign rsp_ready = (st_q == L_RSP);
endmodule

// File: rtl/smb_blkrd_seq.sv
module smb_blkrd_seq
  import smb_blkrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          advance,
  input  logic          kill,
  input  logic          last_byte,
  input  logic [DW-1:0] slave_byte,
  input  logic [DW-1:0] cmd_byte,
  input  logic          done,
  input  logic          done_nack,
  output logic          req,
  output bus_op_e       req_op,
  output logic [DW-1:0] req_byte,
  output ev_t           ev
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_e;
  st_e           st_q, st_d;
  step_e         step_q, step_d;
  logic          kp_q, kp_d, req_d;
  bus_op_e       op_d;
  logic [DW-1:0] byte_d;
  logic [DW-1:0] addr_wr, addr_rd;
  logic          addr_phase;

  // direction bit of the programmed address is replaced in both phases
  assign addr_wr    = {slave_byte[DW-1:1], 1'b0};
  assign addr_rd    = {slave_byte[DW-1:1], 1'b1};
  assign addr_phase = (step_q == STEP_AW) || (step_q == STEP_CMD) || (step_q == STEP_AR);

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    req_d  = 1'b0;
    op_d   = req_op;
    byte_d = req_byte;
    ev     = '0;
    kp_d   = kp_q || (kill && st_q != S_IDLE);
    case (st_q)
      S_IDLE: begin
        kp_d = 1'b0;
        if (go) begin
          req_d = 1'b1; op_d = OP_START; byte_d = addr_wr;
          step_d = STEP_AW; st_d = S_RUN;
        end
      end
      S_HOLD: begin
        if (kp_d) begin
          req_d = 1'b1; op_d = OP_STOP; byte_d = '0;
          step_d = STEP_STOP_KILL; st_d = S_RUN;
        end else if (advance) begin
          req_d  = 1'b1;
          byte_d = '0;
          op_d   = last_byte ? OP_RECV_NACK : OP_RECV_ACK;
          step_d = last_byte ? STEP_RXL : STEP_RX;
          st_d   = S_RUN;
        end
      end
      S_RUN: if (done) begin
        case (step_q)
          STEP_STOP_OK:   begin ev.fin   = 1'b1; st_d = S_IDLE; kp_d = 1'b0; end
          STEP_STOP_ERR:  begin ev.err   = 1'b1; st_d = S_IDLE; kp_d = 1'b0; end
          STEP_STOP_KILL: begin ev.abort = 1'b1; st_d = S_IDLE; kp_d = 1'b0; end
          default: begin
            ev.data = (step_q == STEP_RX) || (step_q == STEP_RXL);
            if (addr_phase && done_nack) begin
              req_d = 1'b1; op_d = OP_STOP; byte_d = '0; step_d = STEP_STOP_ERR;
            end else if (kp_d) begin
              req_d = 1'b1; op_d = OP_STOP; byte_d = '0; step_d = STEP_STOP_KILL;
            end else begin
              case (step_q)
                STEP_AW: begin
                  req_d = 1'b1; op_d = OP_SEND; byte_d = cmd_byte; step_d = STEP_CMD;
                end
                STEP_CMD: begin
                  req_d = 1'b1; op_d = OP_START; byte_d = addr_rd; step_d = STEP_AR;
                end
                STEP_AR: begin
                  req_d = 1'b1; op_d = OP_RECV_ACK; byte_d = '0; step_d = STEP_RX;
                end
                STEP_RX: begin
                  ev.byte_done = 1'b1; st_d = S_HOLD;
                end
                default: begin
                  req_d = 1'b1; op_d = OP_STOP; byte_d = '0; step_d = STEP_STOP_OK;
                end
              endcase
            end
          end
        endcase
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      step_q   <= STEP_AW;
      kp_q     <= 1'b0;
      req      <= 1'b0;
      req_op   <= OP_STOP;
      req_byte <= '0;
    end else begin
      st_q     <= st_d;
      step_q   <= step_d;
      kp_q     <= kp_d;
      req      <= req_d;
      req_op   <= op_d;
      req_byte <= byte_d;
    end
  end
endmodule

// File: rtl/smb_blkrd_host.sv
module smb_blkrd_host
  import smb_blkrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              bus_cmd_valid,
  input  logic              bus_cmd_ready,
  output logic [2:0]        bus_cmd_op,
  output logic [DW-1:0]     bus_cmd_byte,
  input  logic              bus_rsp_valid,
  output logic              bus_rsp_ready,
  input  logic [DW-1:0]     bus_rsp_byte,
  input  logic              bus_rsp_nack
);
  logic          go_w, adv_w, kill_w, last_w, irq_en_w;
  logic [DW-1:0] cmd_w, slave_w, stat_w, done_byte_w, req_byte_w;
  logic          req_w, done_w, done_nack_w;
  bus_op_e       req_op_w, cmd_op_w;
  ev_t           ev_w;

  smb_blkrd_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev(ev_w), .ev_byte(done_byte_w),
    .go(go_w), .advance(adv_w), .kill(kill_w), .last_byte(last_w),
    .irq_en(irq_en_w), .cmd_byte(cmd_w), .slave_byte(slave_w),
    .stat(stat_w), .irq(irq)
  );

  smb_blkrd_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .advance(adv_w), .kill(kill_w),
    .last_byte(last_w), .slave_byte(slave_w), .cmd_byte(cmd_w),
    .done(done_w), .done_nack(done_nack_w), .req(req_w), .req_op(req_op_w),
    .req_byte(req_byte_w), .ev(ev_w)
  );

  smb_blkrd_link #(.DW(DW)) u_link (
    .clk(clk), .rst_n(rst_n), .req(req_w), .req_op(req_op_w), .req_byte(req_byte_w),
    .done(done_w), .done_byte(done_byte_w), .done_nack(done_nack_w),
    .cmd_valid(bus_cmd_valid), .cmd_ready(bus_cmd_ready), .cmd_op(cmd_op_w),
    .cmd_byte(bus_cmd_byte), .rsp_valid(bus_rsp_valid), .rsp_ready(bus_rsp_ready),
    .rsp_byte(bus_rsp_byte), .rsp_nack(bus_rsp_nack)
  );

  assign bus_cmd_op = cmd_op_w;
endmodule

// File: rtl/smb_blkrd_chk.sv
module smb_blkrd_chk
  import smb_blkrd_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              irq,
  input logic              irq_en,
  input logic [DW-1:0]     stat,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [DW-1:0]     cmd_byte,
  input logic              rsp_ready
);
  logic fire, in_xfer, nack_seen;
  assign fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_xfer   <= 1'b0;
      nack_seen <= 1'b0;
    end else if (fire) begin
      if (cmd_op == OP_START) in_xfer <= 1'b1;
      if (cmd_op == OP_STOP)  in_xfer <= 1'b0;
      nack_seen <= (cmd_op == OP_RECV_NACK);
    end
  end

  a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  a_r10_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));
  a_r1_dir_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == OP_START |-> cmd_byte[0] == in_xfer);
  a_r6_stop_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    fire && nack_seen |-> cmd_op == OP_STOP);
  a_r3_bd_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stat[SB_BYTE] |-> stat[SB_BUSY]);
  a_r5_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == RA_STAT && !reg_wdata[SB_BYTE] && stat[SB_BYTE]
    |=> stat[SB_BYTE] && !cmd_valid);
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind smb_blkrd_host smb_blkrd_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .irq_en(irq_en_w), .stat(stat_w),
  .cmd_valid(bus_cmd_valid), .cmd_ready(bus_cmd_ready), .cmd_op(bus_cmd_op),
  .cmd_byte(bus_cmd_byte), .rsp_ready(bus_rsp_ready)
);

// File: tb/smb_blkrd_host_test.sv
`timescale 1ns/1ps
module smb_blkrd_host_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid = 1'b0, rsp_ready;
  logic [7:0] rsp_byte = '0;
  logic       rsp_nack = 1'b0;

  int errors = 0, checks = 0, fire_cnt = 0;
  logic [10:0] expq[$];
  logic [7:0]  pat_base = 8'hA0, pat = '0;
  logic        nack_cmd = 1'b0, sl_busy = 1'b0;
  logic [2:0]  sl_op = '0;
  logic [7:0]  sl_byte = '0;
  int          dly = 0;

  always #4 clk = ~clk;

  smb_blkrd_host uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_cmd_valid(cmd_valid), .bus_cmd_ready(cmd_ready), .bus_cmd_op(cmd_op),
    .bus_cmd_byte(cmd_byte), .bus_rsp_valid(rsp_valid), .bus_rsp_ready(rsp_ready),
    .bus_rsp_byte(rsp_byte), .bus_rsp_nack(rsp_nack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  always @(posedge clk) begin
    if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
      sl_busy   <= 1'b0;
    end else if (sl_busy && !rsp_valid) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        rsp_valid <= 1'b1;
        rsp_byte  <= 8'h00;
        rsp_nack  <= 1'b0;
        case (sl_op)
          3'd0: rsp_nack <= (sl_byte[7:1] != 7'h50);
          3'd1: rsp_nack <= nack_cmd;
          3'd2, 3'd3: begin rsp_byte <= pat; pat <= pat + 8'd1; end
          default: ;
        endcase
      end
    end
    if (cmd_valid && cmd_ready) begin
      cmd_ready <= 1'b0;
      sl_busy   <= 1'b1;
      sl_op     <= cmd_op;
      sl_byte   <= cmd_byte;
      dly       <= fire_cnt % 3;
      if (cmd_op == 3'd0 && cmd_byte[0]) pat <= pat_base;
      fire_cnt  <= fire_cnt + 1;
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6/R10 unexpected op actual=%0h expected=none", cmd_op);
      end else begin
        logic [10:0] e;
        e = expq.pop_front();
        check("R1/R2/R6/R7/R8 op order", cmd_op, e[10:8]);
        if (cmd_op <= 3'd1) check("R1 op byte", cmd_byte, e[7:0]);
      end
    end else if (cmd_valid && !sl_busy && !cmd_ready && (fire_cnt % 2 == 0)) begin
      cmd_ready <= 1'b1;
    end else if (cmd_valid && !sl_busy && !cmd_ready) begin
      cmd_ready <= 1'b1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic expect_op(input logic [2:0] op, input logic [7:0] b);
    expq.push_back({op, b});
  endtask

  task automatic wait_stat(input int bitn, input logic val);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (s[bitn] == val) return;
    end
    check("wait status bit", 0, 1);
  endtask

  task automatic run_read(input int n, input logic ien, input logic probe);
    logic [7:0] v;
    int f0;
    pat_base = pat_base + 8'h10;
    expect_op(3'd0, 8'hA0);
    expect_op(3'd1, 8'h3C);
    expect_op(3'd0, 8'hA1);
    for (int i = 0; i < n - 1; i++) expect_op(3'd2, 8'h00);
    expect_op(3'd3, 8'h00);
    expect_op(3'd4, 8'h00);
    wr(3'd3, 8'hA1);  // R1: direction bit set but ignored
    wr(3'd2, 8'h3C);
    wr(3'd0, {7'd0, ien} | 8'h02);
    for (int i = 0; i < n - 1; i++) begin
      wait_stat(3, 1'b1);
      rd(3'd4, v); check("R3/R7 data byte", v, pat_base + 8'(i));
      rd(3'd1, v); check("R3/R7 status busy+byte-done", v, 8'h09);
      if (probe && i == 0) begin
        f0 = fire_cnt;
        wr(3'd1, 8'h07);               // R4/R5: no byte-done bit
        wr(3'd0, {7'd0, ien} | 8'h02); // R11: start while busy
        repeat (20) @(negedge clk);
        check("R5/R11 no bus op", fire_cnt, f0);
        rd(3'd1, v); check("R4/R5 status kept", v, 8'h09);
        rd(3'd4, v); check("R5 data unchanged", v, pat_base);
      end
      if (i == n - 2) wr(3'd0, {7'd0, ien} | 8'h08);
      wr(3'd1, 8'h08);
    end
    wait_stat(1, 1'b1);
    rd(3'd4, v); check("R6 final byte", v, pat_base + 8'(n - 1));
    rd(3'd1, v); check("R6 status done, busy clear", v, 8'h02);
    check("R9 irq after done", irq, ien);
    check("R6 all ops seen, one stop", expq.size(), 0);
    wr(3'd1, 8'h02);
    check("R9 irq after clear", irq, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd1, v); check("reset status", v, 8'h00);
    check("reset irq", irq, 0);
    check("reset cmd_valid", cmd_valid, 0);

    run_read(4, 1'b1, 1'b1);
    run_read(2, 1'b0, 1'b0);   // R9 masked
    run_read(6, 1'b1, 1'b0);

    // R2: address phase NACK
    expect_op(3'd0, 8'h46); expect_op(3'd4, 8'h00);
    wr(3'd3, 8'h47); wr(3'd0, 8'h03);
    wait_stat(2, 1'b1);
    rd(3'd1, v); check("R2 addr nack status", v, 8'h04);
    check("R9 irq on error", irq, 1);
    check("R2 addr nack ops", expq.size(), 0);
    wr(3'd1, 8'h04);

    // R2: command phase NACK
    nack_cmd = 1'b1;
    expect_op(3'd0, 8'hA0); expect_op(3'd1, 8'h3C); expect_op(3'd4, 8'h00);
    wr(3'd3, 8'hA0); wr(3'd0, 8'h03);
    wait_stat(2, 1'b1);
    rd(3'd1, v); check("R2 cmd nack status", v, 8'h04);
    check("R2 cmd nack ops", expq.size(), 0);
    wr(3'd1, 8'h04);
    nack_cmd = 1'b0;

    // R8: kill while holding a byte
    expect_op(3'd0, 8'hA0); expect_op(3'd1, 8'h3C); expect_op(3'd0, 8'hA1);
    expect_op(3'd2, 8'h00); expect_op(3'd4, 8'h00);
    wr(3'd0, 8'h03);
    wait_stat(3, 1'b1);
    wr(3'd0, 8'h05);
    wait_stat(0, 1'b0);
    repeat (5) @(negedge clk);
    rd(3'd1, v); check("R8 kill status", v, 8'h00);
    check("R8 kill irq", irq, 0);
    check("R8 kill ops, one stop", expq.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule